// File: doc/BRIEF.md
# Four-Mode 4x4 Block Transform Engine

This block applies one of four separable 4x4 integer transforms to a block of sixteen signed samples: the forward core transform, its inverse, a forward Hadamard and an inverse Hadamard. Each block enters as two beats of eight samples, and the mode is chosen per block. Results leave as two beats of eight values. With the output side always ready, a new block can start every two cycles, so eight samples go in and eight results come out on every clock.

The horizontal pass runs on each incoming row as it arrives. The vertical pass combines whole rows element by element. The second pass therefore gathers columns purely by wiring, and no transpose store sits between the passes. The two halves of the beat protocol are interleaved: while the second result beat of one block drains, the first input beat of the next block is taken. Valid/ready handshakes on both sides allow either side to stall. Blocks leave in the order they entered.

Top module: `mt_multixform4`

## Requirements
- R1: While reset is held and in the cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: A block is sent as two beats. Beat 0 holds rows 0 and 1, beat 1 holds rows 2 and 3. Lane l = 4*r + c of a beat carries local row r and column c. Input lane l sits at bits [16l+15:16l] and output lane l at bits [22l+21:22l]. Output beats use the same row order as the input beats.
- R3: Mode 0 (forward core) gives Y = C·X·Cᵀ, where C has rows (1,1,1,1), (2,1,-1,-2), (1,-1,-1,1) and (1,-2,2,-1).
- R4: Mode 1 (inverse core) gives Y = T·X·Tᵀ, where T has rows (1,1,1,½), (1,½,-1,-1), (1,-½,-1,1) and (1,-1,1,-½). Each ½ term is the operand shifted right arithmetically by one, and its sign is applied after the shift. This holds in both passes.
- R5: Mode 2 (forward Hadamard) gives floor((H·X·Hᵀ)/2). H has rows (1,1,1,1), (1,1,-1,-1), (1,-1,-1,1) and (1,-1,1,-1).
- R6: Mode 3 (inverse Hadamard) gives H·X·Hᵀ, with no scaling.
- R7: The mode is sampled with beat 0. The mode input during beat 1 has no effect on the block.
- R8: With out_ready high, result beat 0 is valid in the cycle after input beat 1 is accepted, and result beat 1 is valid in the cycle after that.
- R9: While out_ready stays high, in_ready stays high, so one block is taken every two cycles.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold steady. No beat is lost or reordered.
- R11: For every 16-bit input, including all-extreme blocks, the 22-bit results are exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_mode | input | 2 | Transform select, sampled on beat 0 |
| in_data | input | 128 | Eight signed 16-bit samples |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 176 | Eight signed 22-bit results |

## Verification
Result beat 0 of a block is due one cycle after its second input beat is accepted, and result beat 1 one cycle later, provided the consumer is ready. Under backpressure each beat waits until it is taken. The bench models this with a queue of expected beats. Each queue entry is pushed when the second input beat is seen accepted, and it is compared only on a cycle where valid and ready are both high. Handshakes and outputs are sampled at the falling edge. A directed run checks the exact due cycles against the acceptance edge. Another run with the output always ready checks that the input side never stalls.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    XF_FWD_CORE = 2'd0,
    XF_INV_CORE = 2'd1,
    XF_FWD_HAD  = 2'd2,
    XF_INV_HAD  = 2'd3
  } xform_e;

  localparam int LANES     = 4;  // samples per row
  localparam int BEAT_ROWS = 2;  // rows per beat
  localparam int ROW_GROWTH = 3; // bits added by one pass
endpackage

// File: rtl/mt_xform4.sv
module mt_xform4
  import mt_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = 19
) (
  input  logic [LANES*IW-1:0] vec_i,
  input  xform_e              mode_i,
  output logic [LANES*OW-1:0] vec_o
);
  logic signed [OW-1:0] a [LANES];
  logic signed [OW-1:0] y [LANES];
  logic signed [OW-1:0] s0, s1, s2, s3, e, f, g, h;

  for (genvar k = 0; k < LANES; k++) begin : g_ext
    assign a[k] = {{(OW-IW){vec_i[k*IW+IW-1]}}, vec_i[k*IW +: IW]};
    assign vec_o[k*OW +: OW] = y[k];
  end

  always_comb begin
    s0 = a[0] + a[3];
    s3 = a[0] - a[3];
    s1 = a[1] + a[2];
    s2 = a[1] - a[2];
    e  = a[0] + a[2];
    f  = a[0] - a[2];
    g  = (a[1] >>> 1) - a[3];
    h  = a[1] + (a[3] >>> 1);
    case (mode_i)
      XF_FWD_CORE: begin
        y[0] = s0 + s1;
        y[1] = (s3 <<< 1) + s2;
        y[2] = s0 - s1;
        y[3] = s3 - (s2 <<< 1);
      end
      XF_INV_CORE: begin
        y[0] = e + h;
        y[1] = f + g;
        y[2] = f - g;
        y[3] = e - h;
      end
      default: begin
        y[0] = s0 + s1;
        y[1] = s3 + s2;
        y[2] = s0 - s1;
        y[3] = s3 - s2;
      end
    endcase
  end
endmodule

// File: rtl/mt_flow.sv
module mt_flow (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic second_beat,
  output logic load_first,
  output logic load_block,
  output logic advance_tail,
  output logic out_valid
);
  logic beat_q, out_v_q, tail_v_q;

  assign in_ready     = !beat_q || (!tail_v_q && (!out_v_q || out_ready));
  assign load_first   = in_valid && in_ready && !beat_q;
  assign load_block   = in_valid && in_ready && beat_q;
  assign advance_tail = !load_block && tail_v_q && out_ready;
  assign second_beat  = beat_q;
  assign out_valid    = out_v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q   <= 1'b0;
      out_v_q  <= 1'b0;
      tail_v_q <= 1'b0;
    end else begin
      if (in_valid && in_ready) beat_q <= !beat_q;
      if (load_block) begin
        out_v_q  <= 1'b1;
        tail_v_q <= 1'b1;
      end else if (advance_tail) begin
        tail_v_q <= 1'b0;
      end else if (out_v_q && out_ready) begin
        out_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mt_multixform4.sv
module mt_multixform4
  import mt_pkg::*;
#(
  parameter  int IN_W  = 16,
  localparam int OUT_W = IN_W + 2*ROW_GROWTH,
  localparam int BEAT_IN  = BEAT_ROWS*LANES*IN_W,
  localparam int BEAT_OUT = BEAT_ROWS*LANES*OUT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_mode,
  input  logic [BEAT_IN-1:0]  in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BEAT_OUT-1:0] out_data
);
  localparam int ROW_W = IN_W + ROW_GROWTH;
  localparam int ROWV  = LANES*ROW_W;

  logic   second_beat, load_first, load_block, advance_tail;
  xform_e mode_q, row_mode;
  logic [ROWV-1:0] hold_q [BEAT_ROWS];
  logic [ROWV-1:0] z_row  [BEAT_ROWS];
  logic [LANES*OUT_W-1:0] col_out [LANES];
  logic [2*BEAT_OUT-1:0]  blk_res;
  logic [BEAT_OUT-1:0]    out_q, tail_q;

  mt_flow u_flow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .second_beat(second_beat), .load_first(load_first),
    .load_block(load_block), .advance_tail(advance_tail), .out_valid(out_valid)
  );

  assign row_mode = second_beat ? mode_q : xform_e'(in_mode);

  // horizontal pass, one unit per row of the beat
  for (genvar r = 0; r < BEAT_ROWS; r++) begin : g_row
    mt_xform4 #(.IW(IN_W), .OW(ROW_W)) u_row (
      .vec_i(in_data[r*LANES*IN_W +: LANES*IN_W]),
      .mode_i(row_mode),
      .vec_o(z_row[r])
    );
  end

  // vertical pass: column j gathered from the held and the current rows
  for (genvar j = 0; j < LANES; j++) begin : g_col
    logic [LANES*ROW_W-1:0] col_in;
    assign col_in = {z_row[1][j*ROW_W +: ROW_W], z_row[0][j*ROW_W +: ROW_W],
                     hold_q[1][j*ROW_W +: ROW_W], hold_q[0][j*ROW_W +: ROW_W]};
    mt_xform4 #(.IW(ROW_W), .OW(OUT_W)) u_col (
      .vec_i(col_in),
      .mode_i(mode_q),
      .vec_o(col_out[j])
    );
    for (genvar i = 0; i < LANES; i++) begin : g_scale
      logic signed [OUT_W-1:0] yv;
      assign yv = col_out[j][i*OUT_W +: OUT_W];
      assign blk_res[(i*LANES+j)*OUT_W +: OUT_W] =
        (mode_q == XF_FWD_HAD) ? (yv >>> 1) : yv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= XF_FWD_CORE;
    else if (load_first) mode_q <= xform_e'(in_mode);
  end

  always_ff @(posedge clk) begin
    if (load_first) begin
      for (int r = 0; r < BEAT_ROWS; r++) hold_q[r] <= z_row[r];
    end
    if (load_block) begin
      out_q  <= blk_res[BEAT_OUT-1:0];
      tail_q <= blk_res[2*BEAT_OUT-1:BEAT_OUT];
    end else if (advance_tail) begin
      out_q <= tail_q;
    end
  end

  assign out_data = out_q;
endmodule

// File: rtl/mt_multixform4_chk.sv
module mt_multixform4_chk #(
  parameter int DW = 176
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          second_beat
);
  logic rst_seen_q = 1'b0;
  always @(posedge clk) begin
    // R1
    if (rst_seen_q) reset_idle_chk: assert (!out_valid && in_ready);
    rst_seen_q <= rst;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  drop_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));

  // R8
  first_due_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && second_beat |=> out_valid);

  // R8
  second_due_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && second_beat ##1 out_ready) |=> out_valid);

  // R9
  ready_free_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready && $past(out_ready) |-> in_ready);
endmodule

bind mt_multixform4 mt_multixform4_chk #(.DW(BEAT_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .second_beat(second_beat)
);

// File: tb/mt_multixform4_test.sv
`timescale 1ns/1ps
module mt_multixform4_test;
  localparam int IW = 16;
  localparam int OW = 22;
  localparam int BI = 8*IW;
  localparam int BO = 8*OW;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [1:0] in_mode = 0;
  logic [BI-1:0] in_data = '0;
  logic [BO-1:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0, bp_on = 0, tp_watch = 0;
  int tp_stalls = 0;
  string cur_tag = "R3";

  logic [BO-1:0] exp_q[$];
  string tag_q[$];
  int cap_x[16];
  int cap_md;
  string cap_tag;
  bit stall_prev = 0;
  logic [BO-1:0] stall_data;

  always #5 clk = ~clk;

  mt_multixform4 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(bit ok, string req, logic [BO-1:0] act, logic [BO-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int coef(int md, int i, int k);
    int c[4];
    case (md)
      0: case (i) 0: c='{2,2,2,2}; 1: c='{4,2,-2,-4}; 2: c='{2,-2,-2,2}; default: c='{2,-4,4,-2}; endcase
      1: case (i) 0: c='{2,2,2,1}; 1: c='{2,1,-2,-2}; 2: c='{2,-1,-2,2}; default: c='{2,-2,2,-1}; endcase
      default: case (i) 0: c='{2,2,2,2}; 1: c='{2,2,-2,-2}; 2: c='{2,-2,-2,2}; default: c='{2,-2,2,-2}; endcase
    endcase
    return c[k];
  endfunction

  function automatic int term(int c, int v);
    if (c == 1) return v >>> 1;
    if (c == -1) return -(v >>> 1);
    return v * (c / 2);
  endfunction

  function automatic void ref_block(input int x[16], input int md, output int y[16]);
    int t[16];
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 4; j++) begin
        t[r*4+j] = 0;
        for (int k = 0; k < 4; k++) t[r*4+j] += term(coef(md, j, k), x[r*4+k]);
      end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        y[i*4+j] = 0;
        for (int k = 0; k < 4; k++) y[i*4+j] += term(coef(md, i, k), t[k*4+j]);
        if (md == 2) y[i*4+j] = y[i*4+j] >>> 1;
      end
  endfunction

  // monitor: handshakes and outputs sampled at the falling edge
  always @(negedge clk) if (!rst && !done) begin
    if (stall_prev) check(out_valid && out_data == stall_data, "R10 stall hold", out_data, stall_data);
    stall_prev = out_valid && !out_ready;
    stall_data = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected beat", out_data, '0);
      else begin
        logic [BO-1:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(out_data == e, tg, out_data, e);
      end
    end
    if (in_valid && in_ready) begin
      if (!uut.second_beat) begin end
    end
    if (tp_watch && in_valid && !in_ready) tp_stalls++;
  end

  // reference capture of accepted beats, tracking the beat phase itself
  bit beat_ph = 0;
  always @(negedge clk) if (!rst && !done && in_valid && in_ready) begin
    for (int l = 0; l < 8; l++)
      cap_x[(beat_ph*2 + l/4)*4 + l%4] = int'($signed(in_data[l*IW +: IW]));
    if (!beat_ph) begin
      cap_md = int'(in_mode);
      cap_tag = cur_tag;
    end else begin
      int y[16];
      ref_block(cap_x, cap_md, y);
      for (int q = 0; q < 2; q++) begin
        logic [BO-1:0] p;
        for (int l = 0; l < 8; l++) p[l*OW +: OW] = OW'(y[(q*2 + l/4)*4 + l%4]);
        exp_q.push_back(p);
        tag_q.push_back(cap_tag);
      end
    end
    beat_ph = !beat_ph;
  end

  always @(posedge clk) begin
    #1;
    if (bp_on) out_ready = ($urandom % 3) != 0;
  end

  task automatic send_beat(logic [BI-1:0] d, int md);
    in_valid = 1;
    in_data = d;
    in_mode = 2'(md);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic send_block(int x[16], int md, int md_b1);
    logic [BI-1:0] d0, d1;
    for (int l = 0; l < 8; l++) begin
      d0[l*IW +: IW] = IW'(x[l]);
      d1[l*IW +: IW] = IW'(x[8+l]);
    end
    send_beat(d0, md);
    send_beat(d1, md_b1);
    in_valid = 0;
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  function automatic int rnd_ext();
    case ($urandom % 4)
      0: return 32767;
      1: return -32768;
      2: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    int x[16];
    string tags[4] = '{"R3 fwd core", "R4 inv core", "R5 fwd hadamard", "R6 inv hadamard"};
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset and right after release
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", BO'(out_valid), BO'(1'b0));
    rst = 0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", BO'(out_valid), BO'(1'b0));
    @(posedge clk);
    #1;

    // R8 / R2: due cycles of both result beats
    for (int k = 0; k < 16; k++) x[k] = k + 1;
    cur_tag = "R2 R3 row order";
    send_block(x, 0, 0);
    @(negedge clk);
    check(out_valid, "R8 beat0 due", BO'(out_valid), BO'(1'b1));
    @(negedge clk);
    check(out_valid, "R8 beat1 due", BO'(out_valid), BO'(1'b1));
    @(negedge clk);
    check(!out_valid, "R8 idle after", BO'(out_valid), BO'(1'b0));
    @(posedge clk);
    #1;

    // R3..R6 random streams, R9 no input stall with out_ready high
    tp_watch = 1;
    for (int md = 0; md < 4; md++) begin
      cur_tag = tags[md];
      for (int b = 0; b < 40; b++) begin
        for (int k = 0; k < 16; k++) x[k] = rnd16();
        send_block(x, md, md);
      end
    end
    tp_watch = 0;
    drain();
    check(tp_stalls == 0, "R9 input stalls", BO'(tp_stalls), '0);

    // R7: mode on the second beat is ignored
    cur_tag = "R7 mode sampled on beat0";
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 16; k++) x[k] = rnd16();
      send_block(x, md, 3 - md);
    end
    drain();

    // R11: extreme-value blocks in every mode
    for (int md = 0; md < 4; md++) begin
      cur_tag = "R11 extremes";
      for (int k = 0; k < 16; k++) x[k] = 32767;
      send_block(x, md, md);
      for (int k = 0; k < 16; k++) x[k] = -32768;
      send_block(x, md, md);
      for (int k = 0; k < 16; k++) x[k] = ((k + k/4) % 2) ? -32768 : 32767;
      send_block(x, md, md);
      for (int b = 0; b < 10; b++) begin
        for (int k = 0; k < 16; k++) x[k] = rnd_ext();
        send_block(x, md, md);
      end
    end
    drain();

    // R10: random backpressure, order and stability
    bp_on = 1;
    cur_tag = "R10 backpressure";
    for (int b = 0; b < 200; b++) begin
      for (int k = 0; k < 16; k++) x[k] = rnd16();
      send_block(x, b % 4, b % 4);
    end
    bp_on = 0;
    out_ready = 1;
    drain();
    check(exp_q.size() == 0, "R10 all beats delivered", BO'(exp_q.size()), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule